// File: doc/BRIEF.md
# Indirect Memory Access Unit

This unit sits beside a small processor core and serves every load and store made through its pointer-indirect ports. It keeps two 16-bit pointers, each written and read as a low byte and a high byte, and a matching data port for each. A core access to a data port is steered by the most significant bit of that port's pointer. When the bit is clear, the access goes to the banked data memory. When it is set, the access goes to the read-only program memory. There it fetches a 14-bit word and keeps only its low byte.

A program memory access costs one more cycle than a data memory access, and the unit reports this on a stall output. The core presents one access per cycle as an offset within the current bank, using `acc_valid`, `acc_we`, `acc_off` and `acc_wdata`. Read results come back one cycle later on `acc_rvalid`/`acc_rdata`, or two cycles later on the program memory path. Both memories sit outside the unit. The data memory answers combinationally. The program memory registers its read word on the clock edge after `pm_en`.

Top module: `ind_mem_unit`

## Requirements
- R1: A data port access whose pointer has bit 15 (bit 7 of the high byte) clear and bank offset bits [6:0] of 2 or more raises `dm_en` in the same cycle. It drives `dm_addr` = pointer bits [14:0] and `dm_we` = `acc_we`. A read returns `dm_rdata` on `acc_rvalid` in the next cycle.
- R2: A data port read whose pointer has bit 15 set raises `pm_en` in the same cycle with `pm_addr` = {high byte bits [6:0], low byte}. The returned byte is bits [7:0] of the fetched 14-bit word.
- R3: A data port write whose pointer has bit 15 set raises neither `pm_en` nor `dm_en`, and it changes no memory.
- R4: Every program memory access raises `stall` in the cycle after the request, for exactly one cycle. A read's byte appears with `acc_rvalid` in the cycle after the stall.
- R5: Any request presented while `stall` is high is ignored. It starts no memory access and writes no pointer.
- R6: Offsets 0 and 1 are data ports 0 and 1, and each uses only its own pointer. Offsets 4/5 are the low/high byte of pointer 0, and 6/7 those of pointer 1. A write changes only the addressed byte. A read returns it on `acc_rvalid` in the next cycle.
- R7: A data port access whose pointer has bit 15 clear and bank offset bits [6:0] of 0 or 1 makes no data memory access. A read of it returns 0, and a write of it has no effect.
- R8: Reset clears both pointers to 0, and it holds `stall` and `acc_rvalid` low.
- R9: Accesses to any other offset start no memory access and produce no `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Core access request |
| acc_we | input | 1 | Request is a write |
| acc_off | input | 7 | Register offset within the bank |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte |
| acc_rvalid | output | 1 | Read byte valid |
| stall | output | 1 | Extra cycle of a program memory access |
| dm_en | output | 1 | Data memory access |
| dm_we | output | 1 | Data memory write |
| dm_addr | output | 15 | Data memory address |
| dm_wdata | output | 8 | Data memory write byte |
| dm_rdata | input | 8 | Data memory read byte (combinational) |
| pm_en | output | 1 | Program memory read |
| pm_addr | output | 15 | Program memory word address |
| pm_rdata | input | 14 | Program memory word, registered after `pm_en` |

## Verification
The bench mixes random pointer byte writes, port reads and writes, pointer readbacks and stray offsets. Pointer low bytes are biased toward bank offsets 0 and 1 so that the self-reference path is hit often, and bit 15 is set about half the time. Pointer patterns at 0x8000 and 0xFFFF test the ends of the program memory range and show that bit 15 is stripped from the address. A bank-1 pointer with offset 0 shows that self-reference is decided on the bank offset alone. A request held through a stall shows whether the unit drops it. Pointers 0 and 1 are given different targets so that a port wired to the wrong pointer shows up as a wrong address.

// File: rtl/ind_mem_pkg.sv
package ind_mem_pkg;

    // Where a data port access is routed
    typedef enum logic [1:0] {
        PT_DATA = 2'd0,
        PT_PROG = 2'd1,
        PT_SELF = 2'd2
    } port_tgt_e;

    // Register layout within each bank: ports first, pointer bytes from here
    localparam int PORT_BASE = 0;
    localparam int PTR_BASE  = 4;

endpackage

// File: rtl/ind_ptr_file.sv
module ind_ptr_file #(
    parameter int NUM_PTR = 2,
    parameter int BYTE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [((NUM_PTR > 1) ? $clog2(NUM_PTR) : 1)-1:0] wr_sel,
    input  logic                           wr_hi,
    input  logic [BYTE_W-1:0]              wr_data,
    output logic [2*BYTE_W-1:0]            ptr_q [NUM_PTR]
);
    localparam int PTR_W = 2 * BYTE_W;
    localparam int IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

    logic [PTR_W-1:0] ptr_d [NUM_PTR];

    always_comb begin
        for (int i = 0; i < NUM_PTR; i++) begin
            ptr_d[i] = ptr_q[i];
            if (wr_en && wr_sel == IDX_W'(i)) begin
                if (wr_hi) ptr_d[i][PTR_W-1:BYTE_W] = wr_data;
                else       ptr_d[i][BYTE_W-1:0]     = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PTR; i++) ptr_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PTR; i++) ptr_q[i] <= ptr_d[i];
        end
    end

    // A pointer not addressed by a write keeps its value
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_hold_chk
        AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == IDX_W'(g)) |=> $stable(ptr_q[g])); // R6
    end

endmodule

// File: rtl/ind_route.sv
module ind_route
    import ind_mem_pkg::*;
#(
    parameter int PTR_W      = 16,
    parameter int OFF_W      = 7,
    parameter int NUM_PTR    = 2
) (
    input  logic [PTR_W-1:0]  ptr,
    output port_tgt_e         tgt,
    output logic [PTR_W-2:0]  mem_addr
);
    localparam logic [OFF_W-1:0] PORT_LIMIT = OFF_W'(PORT_BASE + NUM_PTR);

    logic [OFF_W-1:0] bank_off;

    always_comb begin
        bank_off = ptr[OFF_W-1:0];
        mem_addr = ptr[PTR_W-2:0];
        if (ptr[PTR_W-1])
            tgt = PT_PROG;
        else if (bank_off < PORT_LIMIT)
            tgt = PT_SELF;
        else
            tgt = PT_DATA;
    end

endmodule

// File: rtl/ind_mem_unit.sv
module ind_mem_unit
    import ind_mem_pkg::*;
#(
    parameter int NUM_PTR = 2,
    parameter int BYTE_W  = 8,
    parameter int PM_W    = 14,
    parameter int OFF_W   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_we,
    input  logic [OFF_W-1:0]       acc_off,
    input  logic [BYTE_W-1:0]      acc_wdata,
    output logic [BYTE_W-1:0]      acc_rdata,
    output logic                   acc_rvalid,
    output logic                   stall,
    output logic                   dm_en,
    output logic                   dm_we,
    output logic [2*BYTE_W-2:0]    dm_addr,
    output logic [BYTE_W-1:0]      dm_wdata,
    input  logic [BYTE_W-1:0]      dm_rdata,
    output logic                   pm_en,
    output logic [2*BYTE_W-2:0]    pm_addr,
    input  logic [PM_W-1:0]        pm_rdata
);
    localparam int PTR_W = 2 * BYTE_W;
    localparam int IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
    localparam logic [OFF_W-1:0] PORT_LO = OFF_W'(PORT_BASE);
    localparam logic [OFF_W-1:0] PORT_HI = OFF_W'(PORT_BASE + NUM_PTR);
    localparam logic [OFF_W-1:0] PREG_LO = OFF_W'(PTR_BASE);
    localparam logic [OFF_W-1:0] PREG_HI = OFF_W'(PTR_BASE + 2 * NUM_PTR);

    typedef struct packed {
        logic              stall;
        logic              pm_rd;
        logic              rvalid;
        logic [BYTE_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [PTR_W-1:0] ptr_q [NUM_PTR];
    logic             accept;
    logic             port_hit;
    logic             preg_hit;
    logic             port_go;
    logic [OFF_W-1:0] port_rel;
    logic [OFF_W-1:0] preg_rel;
    logic [IDX_W-1:0] port_idx;
    logic [IDX_W-1:0] preg_idx;
    logic             preg_hi;
    logic [PTR_W-1:0] sel_ptr;
    logic [PTR_W-1:0] preg_val;
    port_tgt_e        tgt;
    logic [PTR_W-2:0] mem_addr;
    logic             pf_wr;
    logic             unused_bits;

    // ---------------- request decode ----------------
    always_comb begin
        accept   = acc_valid && !st_q.stall;
        port_hit = (acc_off >= PORT_LO) && (acc_off < PORT_HI);
        preg_hit = (acc_off >= PREG_LO) && (acc_off < PREG_HI);
        port_rel = acc_off - PORT_LO;
        preg_rel = acc_off - PREG_LO;
        port_idx = port_rel[IDX_W-1:0];
        preg_idx = preg_rel[IDX_W:1];
        preg_hi  = preg_rel[0];
        sel_ptr  = ptr_q[port_idx];
        preg_val = ptr_q[preg_idx];
        port_go  = accept && port_hit;
        pf_wr    = accept && acc_we && preg_hit;
    end

    assign unused_bits = ^{pm_rdata[PM_W-1:BYTE_W], port_rel[OFF_W-1:IDX_W],
                           preg_rel[OFF_W-1:IDX_W+1]};

    ind_ptr_file #(
        .NUM_PTR (NUM_PTR),
        .BYTE_W  (BYTE_W)
    ) u_ptr_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pf_wr),
        .wr_sel  (preg_idx),
        .wr_hi   (preg_hi),
        .wr_data (acc_wdata),
        .ptr_q   (ptr_q)
    );

    ind_route #(
        .PTR_W   (PTR_W),
        .OFF_W   (OFF_W),
        .NUM_PTR (NUM_PTR)
    ) u_route (
        .ptr      (sel_ptr),
        .tgt      (tgt),
        .mem_addr (mem_addr)
    );

    // ---------------- memory strobes ----------------
    always_comb begin
        dm_en    = port_go && (tgt == PT_DATA);
        dm_we    = dm_en && acc_we;
        dm_addr  = mem_addr;
        dm_wdata = acc_wdata;
        pm_en    = port_go && (tgt == PT_PROG) && !acc_we;
        pm_addr  = mem_addr;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d        = '0;
        if (st_q.pm_rd) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = pm_rdata[BYTE_W-1:0];
        end else if (port_go) begin
            unique case (tgt)
                PT_PROG: begin
                    st_d.stall = 1'b1;
                    st_d.pm_rd = !acc_we;
                end
                PT_DATA: begin
                    st_d.rvalid = !acc_we;
                    st_d.rdata  = acc_we ? '0 : dm_rdata;
                end
                default: begin
                    st_d.rvalid = !acc_we;
                end
            endcase
        end else if (accept && preg_hit && !acc_we) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = preg_hi ? preg_val[PTR_W-1:BYTE_W] : preg_val[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall      = st_q.stall;
    assign acc_rvalid = st_q.rvalid;
    assign acc_rdata  = st_q.rdata;

    // ---------------- checks ----------------
    AST_PATH_EXCL:    assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_en && pm_en)); // R1
    AST_PM_STALL:     assert property (@(posedge clk) disable iff (!rst_n)
        pm_en |=> stall); // R4
    AST_STALL_ONE:    assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R4
    AST_PM_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(pm_en)) |=> acc_rvalid); // R2
    AST_STALL_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!dm_en && !pm_en && !acc_rvalid)); // R5

endmodule

// File: tb/ind_mem_unit_bench.sv
module ind_mem_unit_bench;
    localparam int K_NONE = 0, K_REG = 1, K_DATA = 2, K_PROG = 3, K_SELF = 4;

    logic        clk, rst_n;
    logic        acc_valid, acc_we;
    logic [6:0]  acc_off;
    logic [7:0]  acc_wdata, acc_rdata;
    logic        acc_rvalid, stall;
    logic        dm_en, dm_we;
    logic [14:0] dm_addr, pm_addr;
    logic [7:0]  dm_wdata, dm_rdata;
    logic        pm_en;
    logic [13:0] pm_rdata;

    logic [7:0]  dm_mem [256];
    logic [7:0]  exp_dm [256];
    logic [15:0] ptr_m [2];
    int          checks, fails;
    bit          done;

    ind_mem_unit u_ind_mem_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .stall(stall), .dm_en(dm_en), .dm_we(dm_we),
        .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .pm_en(pm_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [13:0] pm_word(input logic [14:0] a);
        logic [31:0] t;
        t = (32'(a) * 32'd29) ^ (32'(a) << 5) ^ 32'h1A5;
        return t[13:0];
    endfunction

    // behavioural memories
    assign dm_rdata = dm_mem[dm_addr[7:0]];
    always @(posedge clk) begin
        if (dm_en && dm_we) dm_mem[dm_addr[7:0]] <= dm_wdata;
        if (pm_en) pm_rdata <= pm_word(pm_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic int kind_of(input logic [6:0] off);
        logic [15:0] p;
        if (off < 7'd2) begin
            p = ptr_m[off[0]];
            if (p[15]) return K_PROG;
            if (p[6:0] < 7'd2) return K_SELF;
            return K_DATA;
        end
        if (off >= 7'd4 && off < 7'd8) return K_REG;
        return K_NONE;
    endfunction

    function automatic string tag_of(input int k, input bit we);
        case (k)
            K_DATA:  return "R1";
            K_PROG:  return we ? "R3" : "R2";
            K_SELF:  return "R7";
            K_REG:   return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic access(input bit we, input logic [6:0] off, input logic [7:0] wd);
        int          k;
        string       tg;
        logic [15:0] p;
        logic [7:0]  eb;
        k  = kind_of(off);
        tg = tag_of(k, we);
        p  = ptr_m[off[0]];
        @(negedge clk);
        acc_valid = 1'b1; acc_we = we; acc_off = off; acc_wdata = wd;
        #1;
        chk(dm_en == (k == K_DATA), tg, 32'(dm_en), 32'(k == K_DATA));
        chk(pm_en == (k == K_PROG && !we), tg, 32'(pm_en), 32'(k == K_PROG && !we));
        if (k == K_DATA) begin
            chk(dm_addr == p[14:0], "R1", 32'(dm_addr), 32'(p[14:0]));
            chk(dm_we == we, "R1", 32'(dm_we), 32'(we));
            if (we) chk(dm_wdata == wd, "R1", 32'(dm_wdata), 32'(wd));
        end
        if (k == K_PROG && !we) chk(pm_addr == p[14:0], "R2", 32'(pm_addr), 32'(p[14:0]));
        @(negedge clk);
        chk(stall == (k == K_PROG), "R4", 32'(stall), 32'(k == K_PROG));
        chk(acc_rvalid == (!we && (k == K_DATA || k == K_SELF || k == K_REG)), tg,
            32'(acc_rvalid), 32'(!we && (k == K_DATA || k == K_SELF || k == K_REG)));
        if (!we && k != K_PROG && k != K_NONE) begin
            case (k)
                K_DATA:  eb = exp_dm[p[7:0]];
                K_SELF:  eb = 8'h00;
                default: eb = off[0] ? ptr_m[off[1]][15:8] : ptr_m[off[1]][7:0];
            endcase
            chk(acc_rdata == eb, tg, 32'(acc_rdata), 32'(eb));
        end
        acc_valid = 1'b0;
        if (k == K_PROG) begin
            @(negedge clk);
            chk(stall == 1'b0, "R4", 32'(stall), 32'd0);
            chk(acc_rvalid == !we, tg, 32'(acc_rvalid), 32'(!we));
            if (!we) begin
                eb = pm_word(p[14:0])[7:0];
                chk(acc_rdata == eb, "R2", 32'(acc_rdata), 32'(eb));
            end
        end
        if (k == K_DATA && we) exp_dm[p[7:0]] = wd;
        if (k == K_REG && we) begin
            if (off[0]) ptr_m[off[1]][15:8] = wd;
            else        ptr_m[off[1]][7:0]  = wd;
        end
    endtask

    task automatic set_ptr(input int idx, input logic [15:0] v);
        access(1'b1, 7'(4 + 2 * idx), v[7:0]);
        access(1'b1, 7'(5 + 2 * idx), v[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] old_lo;
        void'($urandom(32'h5eed_1234));
        checks = 0; fails = 0; done = 1'b0;
        acc_valid = 1'b0; acc_we = 1'b0; acc_off = '0; acc_wdata = '0;
        pm_rdata = '0;
        for (int i = 0; i < 256; i++) begin
            dm_mem[i] = 8'(i * 7 + 3);
            exp_dm[i] = 8'(i * 7 + 3);
        end
        ptr_m[0] = '0; ptr_m[1] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(stall == 1'b0 && acc_rvalid == 1'b0, "R8", 32'({stall, acc_rvalid}), 32'd0);
        rst_n = 1'b1;
        // R8: pointers read back as zero
        for (int o = 4; o < 8; o++) access(1'b0, 7'(o), 8'h00);

        // R1 data path, R6 independence
        set_ptr(0, 16'h0123);
        set_ptr(1, 16'h8045);
        access(1'b1, 7'd0, 8'hA5);
        access(1'b0, 7'd0, 8'h00);
        access(1'b0, 7'd1, 8'h00);
        // R2 program range ends
        set_ptr(0, 16'h8000);
        access(1'b0, 7'd0, 8'h00);
        set_ptr(0, 16'hFFFF);
        access(1'b0, 7'd0, 8'h00);
        // R3 program write
        access(1'b1, 7'd0, 8'h3C);
        // R7 self-reference, including bank 1 offset 0
        set_ptr(1, 16'h0001);
        access(1'b1, 7'd1, 8'h77);
        access(1'b0, 7'd1, 8'h00);
        set_ptr(1, 16'h0080);
        access(1'b0, 7'd1, 8'h00);
        access(1'b0, 7'd6, 8'h00);
        // R9 unowned offsets
        access(1'b0, 7'd2, 8'h00);
        access(1'b1, 7'd9, 8'h11);

        // R5: request held during the stall is dropped
        set_ptr(0, 16'h8012);
        old_lo = ptr_m[0][7:0];
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b0; acc_off = 7'd0;
        @(negedge clk);
        acc_we = 1'b1; acc_off = 7'd4; acc_wdata = 8'h55;
        #1;
        chk(stall == 1'b1, "R5", 32'(stall), 32'd1);
        chk(dm_en == 1'b0 && pm_en == 1'b0, "R5", 32'({dm_en, pm_en}), 32'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(acc_rvalid == 1'b1, "R5", 32'(acc_rvalid), 32'd1);
        access(1'b0, 7'd4, 8'h00);
        chk(ptr_m[0][7:0] == old_lo, "R5", 32'(ptr_m[0][7:0]), 32'(old_lo));

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 3) begin
                logic [6:0] off;
                logic [7:0] v;
                off = 7'(4 + $urandom % 4);
                if (off[0]) v = {1'($urandom % 2), 7'($urandom % 3)};
                else if ($urandom % 2 == 0) v = {1'($urandom % 2), 6'd0, 1'($urandom % 2)};
                else v = 8'($urandom);
                access(1'b1, off, v);
            end else if (r < 8) begin
                access(1'($urandom % 2), 7'($urandom % 2), 8'($urandom));
            end else if (r == 8) begin
                access(1'b0, 7'(4 + $urandom % 4), 8'h00);
            end else begin
                access(1'($urandom % 2), ($urandom % 4 == 0) ? 7'(2 + $urandom % 2)
                                                              : 7'(8 + $urandom % 120),
                       8'($urandom));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule